// File: doc/BRIEF.md
# Time-Multiplexed Shared Coefficient Table

This block lets several independent lookup clients read one small coefficient table, in place of one private copy of the table per client. Every client presents a 6-bit index at the start of a slow system cycle. The table runs on a fast clock that is K times the system rate, where K is 2, 3 or 4. It has two read ports, so each fast clock serves two clients. A fixed slot schedule walks through the clients in pairs. The results are gathered and handed back together, all aligned, exactly one system cycle after the indices were taken.

The design uses a single clock. The system-cycle boundary is marked by `sys_en`, a strobe that is high for one fast clock in every K. The table holds 64 words of 14 bits. Its contents are computed at elaboration from two parameters, so no memory file is needed. The number of clients N must not exceed 2*K, and a larger value stops elaboration.

Top module: `shared_coef_rom`

## Requirements
- R1: Table word i (0 to 63) equals (i*COEF_MUL + COEF_OFS) mod 2^14. With the defaults this is (i*347 + 1021) mod 16384.
- R2: Client r places its index in `req_addr[r*6 +: 6]` and receives its word in `rsp_data[r*14 +: 14]`. This holds for both port-A clients (even r) and port-B clients (odd r).
- R3: Indices are sampled only in the fast cycle in which `sys_en` is high. Changes to `req_addr` in any other cycle have no effect on the results.
- R4: The words for indices sampled at one `sys_en` edge appear on `rsp_data` after the next `sys_en` edge, which comes K fast cycles later. `rsp_valid` is high for exactly that one cycle. `sys_en` must recur exactly every K fast cycles once it has first fired.
- R5: All N outputs update together, only at a `sys_en` edge. Between such edges `rsp_data` does not change.
- R6: After reset, `rsp_valid` is low and `rsp_data` is zero. The first `sys_en` after reset does not raise `rsp_valid`.
- R7: Any number of clients may request the same index in the same system cycle, and each of them receives the correct word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast table clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_en | input | 1 | System-cycle strobe, high one cycle in every K |
| req_addr | input | N*ADDR_W | Packed table indices, one field per client |
| rsp_data | output | N*DATA_W | Packed table words, one field per client |
| rsp_valid | output | 1 | One-cycle pulse marking fresh results |

## Verification
The bound checker enforces the timing shape on every cycle:
- `rsp_valid` only ever follows a strobe and never lasts two cycles.
- Outputs hold still between strobes.
- No result appears before the first capture.
- The strobe keeps its period of K.

Whether each word is the right one cannot be seen by a property. That needs the bench scenarios: a sweep that sends every index through every client field, identical indices shared by all clients, and indices scrambled between strobes, all checked against the arithmetic table formula.

// File: rtl/shared_rom_pkg.sv
`timescale 1ns/1ps
package shared_rom_pkg;
  // Arithmetic fill for the coefficient table (R1)
  function automatic logic [31:0] coef_value(input int unsigned idx,
                                             input int unsigned mul,
                                             input int unsigned ofs,
                                             input int unsigned width);
    logic [63:0] full;
    full = 64'(idx) * 64'(mul) + 64'(ofs);
    return 32'(full & ((64'd1 << width) - 64'd1));
  endfunction
endpackage

// File: rtl/coef_dpram.sv
`timescale 1ns/1ps
module coef_dpram #(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 14,
  parameter int COEF_MUL = 347,
  parameter int COEF_OFS = 1021
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr_a,
  input  logic [ADDR_W-1:0] addr_b,
  output logic [DATA_W-1:0] word_a,
  output logic [DATA_W-1:0] word_b
);
  import shared_rom_pkg::*;
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++)
      mem[i] = DATA_W'(coef_value(i, COEF_MUL, COEF_OFS, DATA_W));
  end

  // registered read on both ports, block-RAM friendly
  always_ff @(posedge clk) begin
    word_a <= mem[addr_a];
    word_b <= mem[addr_b];
  end
endmodule

// File: rtl/slot_scheduler.sv
`timescale 1ns/1ps
module slot_scheduler #(
  parameter int N      = 8,
  parameter int K      = 4,
  parameter int ADDR_W = 6,
  parameter int SLOT_W = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sys_en,
  input  logic [N*ADDR_W-1:0] req_addr,
  output logic [ADDR_W-1:0]   port_a_addr,
  output logic [ADDR_W-1:0]   port_b_addr,
  output logic [SLOT_W-1:0]   slot
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(K - 1);

  logic [SLOT_W-1:0] cnt_q;
  logic [ADDR_W-1:0] addr_q [N];
  logic [ADDR_W-1:0] src    [2*K];

  // slot 0 runs in the strobe cycle itself, later slots follow and saturate
  always_ff @(posedge clk) begin
    if (rst)             cnt_q <= LAST;
    else if (sys_en)     cnt_q <= SLOT_W'(1);
    else if (cnt_q != LAST) cnt_q <= cnt_q + SLOT_W'(1);
  end

  assign slot = sys_en ? '0 : cnt_q;

  // index capture on the strobe only (R3)
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < N; j++) addr_q[j] <= '0;
    end else if (sys_en) begin
      for (int j = 0; j < N; j++) addr_q[j] <= req_addr[j*ADDR_W +: ADDR_W];
    end
  end

  // slot 0 reads the live bus, later slots read the captured copy
  always_comb begin
    for (int j = 0; j < 2*K; j++) src[j] = '0;
    for (int j = 0; j < N; j++)
      src[j] = sys_en ? req_addr[j*ADDR_W +: ADDR_W] : addr_q[j];
  end

  assign port_a_addr = src[{slot, 1'b0}];
  assign port_b_addr = src[{slot, 1'b1}];
endmodule

// File: rtl/result_collector.sv
`timescale 1ns/1ps
module result_collector #(
  parameter int N      = 8,
  parameter int K      = 4,
  parameter int DATA_W = 14,
  parameter int SLOT_W = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sys_en,
  input  logic [SLOT_W-1:0]   slot,
  input  logic [DATA_W-1:0]   word_a,
  input  logic [DATA_W-1:0]   word_b,
  output logic [N*DATA_W-1:0] rsp_data,
  output logic                rsp_valid
);
  logic [SLOT_W-1:0] tag_q;
  logic [DATA_W-1:0] gat [N];
  logic              primed_q;

  // table output in this cycle belongs to the slot issued one cycle earlier
  always_ff @(posedge clk) begin
    if (rst) tag_q <= SLOT_W'(K - 1);
    else     tag_q <= slot;
  end

  for (genvar s = 0; s < K; s++) begin : g_pair
    localparam int IA = 2*s;
    localparam int IB = 2*s + 1;
    if (s < K - 1) begin : g_held
      logic [DATA_W-1:0] h_a, h_b;
      always_ff @(posedge clk) begin
        if (rst) begin
          h_a <= '0;
          h_b <= '0;
        end else if (tag_q == SLOT_W'(s)) begin
          h_a <= word_a;
          h_b <= word_b;
        end
      end
      if (IA < N) begin : g_a
        assign gat[IA] = h_a;
      end
      if (IB < N) begin : g_b
        assign gat[IB] = h_b;
      end
    end else begin : g_live
      // last slot lands in the strobe cycle: bypass its holding stage
      if (IA < N) begin : g_a
        assign gat[IA] = word_a;
      end
      if (IB < N) begin : g_b
        assign gat[IB] = word_b;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_data  <= '0;
      rsp_valid <= 1'b0;
      primed_q  <= 1'b0;
    end else begin
      rsp_valid <= sys_en & primed_q;
      if (sys_en) primed_q <= 1'b1;
      if (sys_en && primed_q) begin
        for (int j = 0; j < N; j++) rsp_data[j*DATA_W +: DATA_W] <= gat[j];
      end
    end
  end
endmodule

// File: rtl/shared_coef_rom.sv
`timescale 1ns/1ps
module shared_coef_rom #(
  parameter int N        = 8,
  parameter int K        = 4,
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 14,
  parameter int COEF_MUL = 347,
  parameter int COEF_OFS = 1021
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sys_en,
  input  logic [N*ADDR_W-1:0] req_addr,
  output logic [N*DATA_W-1:0] rsp_data,
  output logic                rsp_valid
);
  localparam int SLOT_W = (K > 2) ? $clog2(K) : 1;

  // two ports times K slots bound the number of clients
  if (N > 2*K || K < 2 || K > 4 || N < 1) begin : g_bad_cfg
    $error("shared_coef_rom: need 2<=K<=4 and 1<=N<=2*K");
  end

  logic [ADDR_W-1:0] port_a_addr, port_b_addr;
  logic [DATA_W-1:0] word_a, word_b;
  logic [SLOT_W-1:0] slot;

  slot_scheduler #(.N(N), .K(K), .ADDR_W(ADDR_W), .SLOT_W(SLOT_W)) u_sched (
    .clk(clk), .rst(rst), .sys_en(sys_en), .req_addr(req_addr),
    .port_a_addr(port_a_addr), .port_b_addr(port_b_addr), .slot(slot)
  );

  coef_dpram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W),
               .COEF_MUL(COEF_MUL), .COEF_OFS(COEF_OFS)) u_table (
    .clk(clk), .addr_a(port_a_addr), .addr_b(port_b_addr),
    .word_a(word_a), .word_b(word_b)
  );

  result_collector #(.N(N), .K(K), .DATA_W(DATA_W), .SLOT_W(SLOT_W)) u_gather (
    .clk(clk), .rst(rst), .sys_en(sys_en), .slot(slot),
    .word_a(word_a), .word_b(word_b),
    .rsp_data(rsp_data), .rsp_valid(rsp_valid)
  );
endmodule

// File: rtl/shared_coef_rom_chk.sv
`timescale 1ns/1ps
module shared_coef_rom_chk #(
  parameter int K = 4,
  parameter int W = 112
) (
  input logic         clk,
  input logic         rst,
  input logic         sys_en,
  input logic [W-1:0] rsp_data,
  input logic         rsp_valid
);
  logic       seen_q;
  logic [3:0] gap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q <= 1'b0;
      gap_q  <= '0;
    end else begin
      if (sys_en) begin
        seen_q <= 1'b1;
        gap_q  <= '0;
      end else if (gap_q != 4'hF) begin
        gap_q <= gap_q + 4'd1;
      end
    end
  end

  assert_valid_after_strobe_R4: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(sys_en));

  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  assert_strobe_period_R4: assert property (@(posedge clk) disable iff (rst)
    seen_q |-> (sys_en == (gap_q == 4'(K - 1))));

  assert_data_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !sys_en |=> $stable(rsp_data));

  assert_no_early_valid_R6: assert property (@(posedge clk) disable iff (rst)
    !seen_q |-> !rsp_valid);
endmodule

bind shared_coef_rom shared_coef_rom_chk #(.K(K), .W(N*DATA_W)) u_chk (
  .clk(clk), .rst(rst), .sys_en(sys_en),
  .rsp_data(rsp_data), .rsp_valid(rsp_valid)
);

// File: tb/test_shared_coef_rom.sv
`timescale 1ns/1ps
module test_shared_coef_rom;
  localparam int N  = 8;
  localparam int K  = 4;
  localparam int AW = 6;
  localparam int DW = 14;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            sys_en = 1'b0;
  logic [N*AW-1:0] req_addr = '0;
  logic [N*DW-1:0] rsp_data;
  logic            rsp_valid;

  int errors = 0;
  int checks = 0;
  logic [N*AW-1:0] prev_addr;
  bit              have_prev = 1'b0;
  logic [N*DW-1:0] held;

  always #5 clk = ~clk;

  shared_coef_rom #(.N(N), .K(K), .ADDR_W(AW), .DATA_W(DW)) i_shared_coef_rom (
    .clk(clk), .rst(rst), .sys_en(sys_en), .req_addr(req_addr),
    .rsp_data(rsp_data), .rsp_valid(rsp_valid)
  );

  function automatic int exp_word(input int a);
    return (a * 347 + 1021) % 16384;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one system cycle: strobe with new indices, then K-1 idle fast cycles
  task automatic run_cycle(input logic [N*AW-1:0] a);
    @(negedge clk);
    sys_en   = 1'b1;
    req_addr = a;
    @(posedge clk); #1;
    if (have_prev) begin
      check(rsp_valid == 1'b1, "R4 valid pulse", rsp_valid, 1);
      for (int r = 0; r < N; r++) begin
        int e;
        e = exp_word(int'(prev_addr[r*AW +: AW]));
        check(rsp_data[r*DW +: DW] == DW'(e), "R1/R2 word per client",
              rsp_data[r*DW +: DW], e);
      end
    end else begin
      check(rsp_valid == 1'b0, "R6 first strobe no valid", rsp_valid, 0);
    end
    held = rsp_data;
    @(negedge clk);
    sys_en   = 1'b0;
    req_addr = ~a;  // R3: off-strobe changes must not matter
    for (int i = 0; i < K - 1; i++) begin
      @(posedge clk); #1;
      check(rsp_valid == 1'b0, "R4 valid one cycle only", rsp_valid, 0);
      check(rsp_data == held, "R5 outputs hold", rsp_data, held);
      if (i < K - 2) @(negedge clk);
    end
    prev_addr = a;
    have_prev = 1'b1;
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [N*AW-1:0] a;
    repeat (3) @(posedge clk);
    #1;
    check(rsp_valid == 1'b0, "R6 reset valid", rsp_valid, 0);
    check(rsp_data == '0, "R6 reset data", rsp_data, 0);
    @(negedge clk);
    rst = 1'b0;
    repeat (2) @(posedge clk);

    // sweep: every index passes through every client field (R1, R2, R3)
    for (int c = 0; c < 64; c++) begin
      for (int r = 0; r < N; r++) a[r*AW +: AW] = AW'((c + r*9) % 64);
      run_cycle(a);
    end
    // all clients asking for one index (R7)
    for (int v = 0; v < 4; v++) begin
      int idx;
      idx = (v == 0) ? 0 : (v == 1) ? 63 : (v == 2) ? 17 : 42;
      for (int r = 0; r < N; r++) a[r*AW +: AW] = AW'(idx);
      run_cycle(a);  // R7 identical indices
    end
    // descending pattern, then a flush cycle for the last results
    for (int r = 0; r < N; r++) a[r*AW +: AW] = AW'(63 - r*7);
    run_cycle(a);
    run_cycle('0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule